// File: doc/BRIEF.md
# Dual-Port Word Memory with Fixed Collision Behaviour

This block is a small synchronous memory with two symmetric access ports, A and B, both clocked from one clock. Each port presents an address, a write word and a write strobe in every cycle and receives a registered read word. The stored words are treated as opaque bit vectors; the default is 16 locations of 13 bits, which is sized to hold a data field plus its check bits.

Both the request side and the read side of each port are registered. A request presented before rising edge N is captured at edge N and acts on the array at edge N+1, and its read word is visible after edge N+1. Every port reads its addressed location on every cycle, whether or not it writes. What a port returns when a write and a read meet at one address in one cycle is fixed and deliberately differs per port. Port A returns the word it is writing. Port B returns the word held before its own write. A port that reads a location the other port is writing sees the previous contents.

A synchronous reset clears the captured write strobes and both read registers. It leaves the array alone.

Top module: `tdp_ram`

## Requirements
- R1: The array holds DEPTH (16) words of DATA_W (13) bits. A word written at an address is returned by a later read of that address from either port.
- R2: Read data for a request presented before rising edge N appears on the port's read output after edge N+1, exactly two edges later, and stays there until after edge N+2.
- R3: When port A writes an address, port A's read output for that request equals the word being written.
- R4: When port B writes an address, port B's read output for that request equals the word stored there before the write.
- R5: When one port writes an address that the other port reads without writing in the same request cycle, the reading port returns the word stored before the write.
- R6: When both ports write the same address in the same request cycle, port A's word is the one stored. Port A returns its own word and port B returns the old word.
- R7: With the write strobe low, a port only reads. Its write word bus has no effect on the array.
- R8: While rst is high at a rising edge, both read outputs become zero and no new request is captured. The array contents are kept across reset.
- R9: The two ports operate independently when their addresses differ. Two writes to different addresses in one cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Common clock for both ports, rising edge |
| rst | input | 1 | Synchronous reset of the captured strobes and the read registers |
| pa_addr | input | ADDR_W (4) | Port A address |
| pa_wdata | input | DATA_W (13) | Port A write word |
| pa_wen | input | 1 | Port A write strobe, high writes |
| pa_rdata | output | DATA_W (13) | Port A registered read word |
| pb_addr | input | ADDR_W (4) | Port B address |
| pb_wdata | input | DATA_W (13) | Port B write word |
| pb_wen | input | 1 | Port B write strobe, high writes |
| pb_rdata | output | DATA_W (13) | Port B registered read word |

## Verification
The bench sweeps every address through each collision pattern and compares each result against a shadow array.

- **Port A own write, port B reading the same address.** A design that forwarded symmetrically would hand B the new word. A design without forwarding on A would return stale data to A.
- **Port B own write, port A reading the same address.** Here a design that forwarded on B would show the new word one cycle early.
- **Both ports writing one address.** A wrong priority leaves port B's word in the array, and the next read-back exposes it.

Every comparison is made exactly two edges after the request, so an extra or missing pipeline stage fails on the first changing word. Write-word buses are driven with garbage while the strobes are low, and a mid-run reset is followed by read-back, to catch stray writes and a cleared array.

// File: rtl/tdp_ram.sv
module tdp_ram #(
  parameter int DATA_W = 13,
  parameter int DEPTH  = 16,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] pa_addr,
  input  logic [DATA_W-1:0] pa_wdata,
  input  logic              pa_wen,
  output logic [DATA_W-1:0] pa_rdata,
  input  logic [ADDR_W-1:0] pb_addr,
  input  logic [DATA_W-1:0] pb_wdata,
  input  logic              pb_wen,
  output logic [DATA_W-1:0] pb_rdata
);

  logic [DATA_W-1:0] mem [DEPTH];

  logic [ADDR_W-1:0] a_addr_q, b_addr_q;
  logic [DATA_W-1:0] a_wdata_q, b_wdata_q;
  logic              a_wen_q, b_wen_q;

  logic same_addr;
  logic b_store;

  assign same_addr = (a_addr_q == b_addr_q);
  assign b_store   = b_wen_q && !(a_wen_q && same_addr);

  always_ff @(posedge clk) begin
    a_addr_q  <= pa_addr;
    b_addr_q  <= pb_addr;
    a_wdata_q <= pa_wdata;
    b_wdata_q <= pb_wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      a_wen_q  <= 1'b0;
      b_wen_q  <= 1'b0;
      pa_rdata <= '0;
      pb_rdata <= '0;
    end else begin
      a_wen_q  <= pa_wen;
      b_wen_q  <= pb_wen;
      pa_rdata <= a_wen_q ? a_wdata_q : mem[a_addr_q];
      pb_rdata <= mem[b_addr_q];
    end
  end

  always_ff @(posedge clk) begin
    if (a_wen_q) mem[a_addr_q] <= a_wdata_q;
    if (b_store) mem[b_addr_q] <= b_wdata_q;
  end

endmodule

// File: rtl/tdp_ram_chk.sv
module tdp_ram_chk #(
  parameter int DATA_W = 13,
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] pa_addr,
  input logic [DATA_W-1:0] pa_wdata,
  input logic              pa_wen,
  input logic [DATA_W-1:0] pa_rdata,
  input logic [ADDR_W-1:0] pb_addr,
  input logic              pb_wen,
  input logic [DATA_W-1:0] pb_rdata
);

  logic [1:0] seen = 2'd0;
  logic       started = 1'b0;

  always_ff @(posedge clk) begin
    started <= 1'b1;
    if (rst) seen <= 2'd0;
    else if (seen != 2'd3) seen <= seen + 2'd1;
  end

  // R3
  a_own_new_chk: assert property (@(posedge clk) disable iff (rst)
    (seen == 2'd3 && $past(pa_wen, 2)) |-> pa_rdata == $past(pa_wdata, 2));

  // R4
  b_own_old_chk: assert property (@(posedge clk) disable iff (rst)
    (seen == 2'd3 && $past(pb_wen, 2) && !$past(pa_wen, 2) &&
     $past(pa_addr, 2) == $past(pb_addr, 2)) |-> pb_rdata == pa_rdata);

  // R1
  same_read_chk: assert property (@(posedge clk) disable iff (rst)
    (seen == 2'd3 && !$past(pa_wen, 2) && !$past(pb_wen, 2) &&
     $past(pa_addr, 2) == $past(pb_addr, 2)) |-> pb_rdata == pa_rdata);

  // R8
  reset_out_chk: assert property (@(posedge clk) disable iff (!started)
    $past(rst) |-> (pa_rdata == '0 && pb_rdata == '0));

endmodule

bind tdp_ram tdp_ram_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst(rst),
  .pa_addr(pa_addr), .pa_wdata(pa_wdata), .pa_wen(pa_wen), .pa_rdata(pa_rdata),
  .pb_addr(pb_addr), .pb_wen(pb_wen), .pb_rdata(pb_rdata)
);

// File: tb/tdp_ram_tb_top.sv
module tdp_ram_tb_top;
  localparam int DW = 13;
  localparam int N  = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [3:0]    pa_addr = '0, pb_addr = '0;
  logic [DW-1:0] pa_wdata = '0, pb_wdata = '0;
  logic          pa_wen = 1'b0, pb_wen = 1'b0;
  logic [DW-1:0] pa_rdata, pb_rdata;

  always #2ns clk = ~clk;

  tdp_ram dut_i (
    .clk(clk), .rst(rst),
    .pa_addr(pa_addr), .pa_wdata(pa_wdata), .pa_wen(pa_wen), .pa_rdata(pa_rdata),
    .pb_addr(pb_addr), .pb_wdata(pb_wdata), .pb_wen(pb_wen), .pb_rdata(pb_rdata)
  );

  int errors = 0;
  int checks = 0;

  logic [DW-1:0] shadow [N];
  logic          known  [N];

  logic [DW-1:0] ea0, eb0, ea1, eb1;
  logic          va0 = 0, vb0 = 0, va1 = 0, vb1 = 0;
  string         ta0, tb0, ta1, tb1;

  function automatic logic [DW-1:0] pat(int i, int k);
    return DW'((i * 613 + k * 97 + 21) % 8192);
  endfunction

  task automatic check(input string tag, input string port, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s port %s: actual=%h expected=%h", tag, port, act, exp);
    end
  endtask

  task automatic step(input logic aw, input int aa, input logic [DW-1:0] ad,
                      input logic bw, input int ba, input logic [DW-1:0] bd,
                      input string ra, input string rb);
    @(negedge clk);
    if (va1) check(ta1, "A", pa_rdata, ea1);
    if (vb1) check(tb1, "B", pb_rdata, eb1);
    ea1 = ea0; eb1 = eb0; va1 = va0; vb1 = vb0; ta1 = ta0; tb1 = tb0;
    va0 = aw || known[aa];
    ea0 = aw ? ad : shadow[aa];
    vb0 = known[ba];
    eb0 = shadow[ba];
    ta0 = ra; tb0 = rb;
    if (bw) begin shadow[ba] = bd; known[ba] = 1'b1; end
    if (aw) begin shadow[aa] = ad; known[aa] = 1'b1; end
    pa_wen = aw; pa_addr = 4'(aa); pa_wdata = ad;
    pb_wen = bw; pb_addr = 4'(ba); pb_wdata = bd;
  endtask

  task automatic flush(input string tag);
    for (int i = 0; i < 3; i++) step(1'b0, i, '1, 1'b0, i, '1, tag, tag);
  endtask

  initial begin
    #400us;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin shadow[i] = '0; known[i] = 1'b0; end
    repeat (3) @(negedge clk);
    check("R8", "A", pa_rdata, '0);
    check("R8", "B", pb_rdata, '0);
    rst = 1'b0;

    // R1 R9: fill, A low half and B high half in the same cycles
    for (int i = 0; i < 8; i++)
      step(1'b1, i, pat(i, 0), 1'b1, i + 8, pat(i + 8, 0), "R3", "R9");
    // R1 R2: read sweep with crossed addresses
    for (int i = 0; i < N; i++)
      step(1'b0, i, '1, 1'b0, N - 1 - i, '0, "R2", "R1");
    // R3 R5: A writes, B reads the same address
    for (int i = 0; i < N; i++)
      step(1'b1, i, pat(i, 1), 1'b0, i, '1, "R3", "R5");
    // R4 R5: B writes, A reads the same address
    for (int i = 0; i < N; i++)
      step(1'b0, i, '1, 1'b1, i, pat(i, 2), "R5", "R4");
    // R6: both write the same address
    for (int i = 0; i < N; i++)
      step(1'b1, i, pat(i, 3), 1'b1, i, pat(i, 4), "R6", "R6");
    for (int i = 0; i < N; i++)
      step(1'b0, i, '0, 1'b0, (i + 5) % N, '0, "R6", "R6");
    // R9: both write different addresses
    for (int i = 0; i < N; i++)
      step(1'b1, i, pat(i, 5), 1'b1, (i + 1) % N, pat(i, 6), "R3", "R9");
    // R7: strobes low with noisy write buses
    for (int i = 0; i < N; i++)
      step(1'b0, i, pat(i, 7) ^ 13'h1555, 1'b0, (i + 3) % N, pat(i, 8), "R7", "R7");
    for (int i = 0; i < N; i++)
      step(1'b0, i, '0, 1'b0, N - 1 - i, '0, "R7", "R7");
    // R2: back-to-back write then read of one address
    for (int i = 0; i < N; i++) begin
      step(1'b1, i, pat(i, 9), 1'b0, i, '0, "R2", "R5");
      step(1'b0, i, '0, 1'b0, i, '0, "R2", "R2");
    end
    flush("R2");

    // R8: mid-run reset, outputs cleared, array kept
    @(negedge clk);
    rst = 1'b1;
    va0 = 0; vb0 = 0; va1 = 0; vb1 = 0;
    @(negedge clk);
    check("R8", "A", pa_rdata, '0);
    check("R8", "B", pb_rdata, '0);
    rst = 1'b0;
    for (int i = 0; i < N; i++)
      step(1'b0, i, '1, 1'b0, N - 1 - i, '1, "R8", "R8");
    flush("R8");

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule